// File: doc/BRIEF.md
# Output Compare and PWM Channel

This block is one compare channel of a timer. A timer base outside the block supplies a 16-bit count value, a strobe that marks each new count, and an update strobe. The channel compares the count with its compare value. From that comparison it builds a reference waveform in one of eight modes. The reference then passes through a polarity and enable stage to reach the pin.

The compare value can be written straight into the active comparator. It can also be held in a buffer and copied to the comparator only on the next update strobe. That lets software change a PWM duty cycle without glitches. Every compare match sets a sticky flag, and the flag raises an interrupt when the interrupt is enabled.

Top module: `occ_channel`

## Requirements
- R1: With mode code 000 the reference holds its value, and a compare match does not change it.
- R2: With mode code 001 a match drives the reference high on the next clock. With mode code 010 a match drives it low. Without a match the reference holds.
- R3: With mode code 011 the reference inverts on every clock in which a match occurs.
- R4: Mode code 100 drives the reference low and mode code 101 drives it high on the next clock, whatever the count value.
- R5: Mode code 110 sets the reference to 1 when the count is below the compare value and to 0 otherwise. Mode code 111 gives the inverse. A compare value of 0 gives a constant low in mode 110. A compare value above every count the counter reaches gives a constant high in mode 110.
- R6: With preload off, a compare write takes effect in the comparator on the next clock.
- R7: With preload on, a compare write goes only into the buffer. The active compare value is unchanged until an update strobe, and the clock after that strobe it holds the buffered value.
- R8: With the output enabled, the pin is the reference XOR the polarity bit. With the output disabled, the pin equals the polarity bit. The pin follows these inputs combinationally.
- R9: A match is a clock in which the count strobe is high and the count equals the active compare value. A match sets the flag on the next clock. A clear request resets the flag unless a match occurs in the same clock, in which case the set wins. The interrupt is the flag ANDed with the interrupt enable.
- R10: After reset the reference, the flag, the interrupt and the active compare value are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Count value from the timer base |
| cnt_adv | input | 1 | High in each clock that presents a new count |
| upd_evt | input | 1 | Update strobe from the timer base |
| cfg_mode | input | 3 | Reference mode code |
| cfg_preload | input | 1 | Buffer compare writes until the next update |
| cfg_pol | input | 1 | Output polarity (1 inverts) |
| cfg_oe | input | 1 | Output enable |
| cfg_irq_en | input | 1 | Compare interrupt enable |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | 16 | Compare write data |
| flag_clr | input | 1 | Clear request for the compare flag |
| cmp_active | output | 16 | Compare value in use by the comparator |
| oc_ref | output | 1 | Reference waveform |
| oc_pin | output | 1 | Pin level after polarity and enable |
| cmp_flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Compare interrupt |

## Verification
A wrong buffer or active compare value shows up on `cmp_active` one clock after the write or update strobe that exposes it. In the match-driven modes it also moves the reference edge to a different count. A wrong reference state shows on `oc_ref` one clock after the match or count that should have set it. Because the pin stage is combinational, the same error reaches `oc_pin` in that same clock. A flag error shows at `cmp_flag` and `irq` on the clock after the match or clear request.

// File: rtl/occ_pkg.sv
package occ_pkg;

    typedef enum logic [2:0] {
        OC_FROZEN = 3'b000,
        OC_SET    = 3'b001,
        OC_CLR    = 3'b010,
        OC_TOG    = 3'b011,
        OC_LOW    = 3'b100,
        OC_HIGH   = 3'b101,
        OC_PWM_A  = 3'b110,
        OC_PWM_B  = 3'b111
    } oc_mode_e;

    typedef struct packed {
        logic hit;    // count equals active compare on an advancing clock
        logic below;  // count strictly below active compare
    } cmp_res_t;

    function automatic logic next_ref(oc_mode_e mode, logic cur, cmp_res_t res);
        logic nxt;
        case (mode)
            OC_FROZEN: nxt = cur;
            OC_SET:    nxt = res.hit ? 1'b1 : cur;
            OC_CLR:    nxt = res.hit ? 1'b0 : cur;
            OC_TOG:    nxt = res.hit ? ~cur : cur;
            OC_LOW:    nxt = 1'b0;
            OC_HIGH:   nxt = 1'b1;
            OC_PWM_A:  nxt = res.below;
            default:   nxt = ~res.below;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/occ_cmp_reg.sv
module occ_cmp_reg #(
    parameter int unsigned W          = 16,
    parameter bit          PRELOAD_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         preload,
    input  logic         upd,
    output logic [W-1:0] active
);

    generate
        if (PRELOAD_EN) begin : g_buf
            logic [W-1:0] shadow_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    shadow_q <= '0;
                    active   <= '0;
                end else begin
                    if (wr_en)
                        shadow_q <= wr_data;
                    if (wr_en && !preload)
                        active <= wr_data;
                    else if (upd)
                        active <= shadow_q;
                end
            end
        end else begin : g_direct
            logic unused_ok;
            assign unused_ok = preload ^ upd;

            always_ff @(posedge clk) begin
                if (rst)
                    active <= '0;
                else if (wr_en)
                    active <= wr_data;
            end
        end
    endgenerate

endmodule

// File: rtl/occ_ref_gen.sv
module occ_ref_gen
    import occ_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   mode,
    input  logic [W-1:0] cnt,
    input  logic         cnt_adv,
    input  logic [W-1:0] cmp,
    output logic         ref_o,
    output logic         hit_o
);

    cmp_res_t res;

    always_comb begin
        res.hit   = cnt_adv && (cnt == cmp);
        res.below = (cnt < cmp);
    end

    assign hit_o = res.hit;

    always_ff @(posedge clk) begin
        if (rst)
            ref_o <= 1'b0;
        else
            ref_o <= next_ref(oc_mode_e'(mode), ref_o, res);
    end

endmodule

// File: rtl/occ_out_stage.sv
module occ_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic ref_i,
    input  logic pol,
    input  logic oe,
    input  logic hit,
    input  logic clr,
    input  logic irq_en,
    output logic pin,
    output logic flag,
    output logic irq
);

    assign pin = oe ? (ref_i ^ pol) : pol;
    assign irq = flag & irq_en;

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

endmodule

// File: rtl/occ_channel.sv
module occ_channel
    import occ_pkg::*;
#(
    parameter int unsigned W          = 16,
    parameter bit          PRELOAD_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt_val,
    input  logic         cnt_adv,
    input  logic         upd_evt,
    input  logic [2:0]   cfg_mode,
    input  logic         cfg_preload,
    input  logic         cfg_pol,
    input  logic         cfg_oe,
    input  logic         cfg_irq_en,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         flag_clr,
    output logic [W-1:0] cmp_active,
    output logic         oc_ref,
    output logic         oc_pin,
    output logic         cmp_flag,
    output logic         irq
);

    logic hit;

    occ_cmp_reg #(.W(W), .PRELOAD_EN(PRELOAD_EN)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmp_wr),
        .wr_data (cmp_wdata),
        .preload (cfg_preload),
        .upd     (upd_evt),
        .active  (cmp_active)
    );

    occ_ref_gen #(.W(W)) u_ref (
        .clk     (clk),
        .rst     (rst),
        .mode    (cfg_mode),
        .cnt     (cnt_val),
        .cnt_adv (cnt_adv),
        .cmp     (cmp_active),
        .ref_o   (oc_ref),
        .hit_o   (hit)
    );

    occ_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .ref_i  (oc_ref),
        .pol    (cfg_pol),
        .oe     (cfg_oe),
        .hit    (hit),
        .clr    (flag_clr),
        .irq_en (cfg_irq_en),
        .pin    (oc_pin),
        .flag   (cmp_flag),
        .irq    (irq)
    );

endmodule

// File: rtl/occ_channel_chk.sv
module occ_channel_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] cnt_val,
    input logic         cnt_adv,
    input logic         upd_evt,
    input logic [2:0]   cfg_mode,
    input logic         cfg_preload,
    input logic         cmp_wr,
    input logic [W-1:0] cmp_wdata,
    input logic [W-1:0] cmp_active,
    input logic         oc_ref,
    input logic         cmp_flag
);

    logic match;
    assign match = cnt_adv && (cnt_val == cmp_active);

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 3'b000) |=> $stable(oc_ref));                          // R1

    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 3'b001 && match) |=> oc_ref);                          // R2

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 3'b011 && match) |=> (oc_ref != $past(oc_ref)));       // R3

    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 3'b100) |=> !oc_ref);                                  // R4

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 3'b101) |=> oc_ref);                                   // R4

    AST_PWM_LOW_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 3'b110 && cmp_active == '0) |=> !oc_ref);              // R5

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cmp_wr && !cfg_preload) |=> (cmp_active == $past(cmp_wdata)));     // R6

    AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_preload && !upd_evt) |=> $stable(cmp_active));                 // R7

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        match |=> cmp_flag);                                                // R9

endmodule

bind occ_channel occ_channel_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_val     (cnt_val),
    .cnt_adv     (cnt_adv),
    .upd_evt     (upd_evt),
    .cfg_mode    (cfg_mode),
    .cfg_preload (cfg_preload),
    .cmp_wr      (cmp_wr),
    .cmp_wdata   (cmp_wdata),
    .cmp_active  (cmp_active),
    .oc_ref      (oc_ref),
    .cmp_flag    (cmp_flag)
);

// File: tb/occ_channel_tb.sv
module occ_channel_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cnt_val;
    logic        cnt_adv;
    logic        upd_evt;
    logic [2:0]  cfg_mode;
    logic        cfg_preload;
    logic        cfg_pol;
    logic        cfg_oe;
    logic        cfg_irq_en;
    logic        cmp_wr;
    logic [15:0] cmp_wdata;
    logic        flag_clr;
    logic [15:0] cmp_active;
    logic        oc_ref;
    logic        oc_pin;
    logic        cmp_flag;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    occ_channel u_dut (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_adv(cnt_adv),
        .upd_evt(upd_evt), .cfg_mode(cfg_mode), .cfg_preload(cfg_preload),
        .cfg_pol(cfg_pol), .cfg_oe(cfg_oe), .cfg_irq_en(cfg_irq_en),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .flag_clr(flag_clr),
        .cmp_active(cmp_active), .oc_ref(oc_ref), .oc_pin(oc_pin),
        .cmp_flag(cmp_flag), .irq(irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // advance one clock; inputs change 1 ns after the edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cnt_at(logic [15:0] v);
        cnt_val = v;
        cnt_adv = 1'b1;
        step();
        cnt_adv = 1'b0;
    endtask

    task automatic write_cmp(logic [15:0] v);
        cmp_wr    = 1'b1;
        cmp_wdata = v;
        step();
        cmp_wr    = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        chk("R10 ref", 16'(oc_ref), 16'h0);
        chk("R10 flag", 16'(cmp_flag), 16'h0);
        chk("R10 irq", 16'(irq), 16'h0);
        chk("R10 active", cmp_active, 16'h0);
    endtask

    task automatic t_direct();
        cfg_preload = 1'b0;
        write_cmp(16'd100);
        chk("R6 direct write", cmp_active, 16'd100);
    endtask

    task automatic t_preload();
        cfg_preload = 1'b1;
        write_cmp(16'd200);
        chk("R7 buffered write held", cmp_active, 16'd100);
        step();
        chk("R7 still held", cmp_active, 16'd100);
        upd_evt = 1'b1;
        step();
        upd_evt = 1'b0;
        chk("R7 transfer on update", cmp_active, 16'd200);
        cfg_preload = 1'b0;
        write_cmp(16'd100);
    endtask

    task automatic t_force();
        cfg_mode = 3'b101;
        cnt_at(16'd7);
        chk("R4 force high", 16'(oc_ref), 16'h1);
        cfg_mode = 3'b100;
        cnt_at(16'd100);
        chk("R4 force low", 16'(oc_ref), 16'h0);
    endtask

    task automatic t_set_clear();
        cfg_mode = 3'b001;
        cnt_at(16'd50);
        chk("R2 set no match", 16'(oc_ref), 16'h0);
        cnt_at(16'd100);
        chk("R2 set on match", 16'(oc_ref), 16'h1);
        cfg_mode = 3'b010;
        cnt_at(16'd60);
        chk("R2 clear no match", 16'(oc_ref), 16'h1);
        cnt_at(16'd100);
        chk("R2 clear on match", 16'(oc_ref), 16'h0);
    endtask

    task automatic t_toggle();
        cfg_mode = 3'b011;
        cnt_at(16'd100);
        chk("R3 toggle 1", 16'(oc_ref), 16'h1);
        cnt_at(16'd101);
        chk("R3 no match hold", 16'(oc_ref), 16'h1);
        cnt_at(16'd100);
        chk("R3 toggle 2", 16'(oc_ref), 16'h0);
        cnt_val = 16'd100;
        step();
        chk("R3 no strobe hold", 16'(oc_ref), 16'h0);
    endtask

    task automatic t_freeze();
        cfg_mode = 3'b101;
        step();
        cfg_mode = 3'b000;
        cnt_at(16'd100);
        chk("R1 frozen at match", 16'(oc_ref), 16'h1);
        cnt_at(16'd3);
        chk("R1 frozen off match", 16'(oc_ref), 16'h1);
    endtask

    task automatic t_pwm();
        int bad = 0;
        cfg_mode = 3'b110;
        cnt_at(16'd99);
        chk("R5 pwm1 below", 16'(oc_ref), 16'h1);
        cnt_at(16'd100);
        chk("R5 pwm1 equal", 16'(oc_ref), 16'h0);
        cnt_at(16'd150);
        chk("R5 pwm1 above", 16'(oc_ref), 16'h0);
        cfg_mode = 3'b111;
        cnt_at(16'd99);
        chk("R5 pwm2 below", 16'(oc_ref), 16'h0);
        cnt_at(16'd150);
        chk("R5 pwm2 above", 16'(oc_ref), 16'h1);
        cfg_mode = 3'b110;
        write_cmp(16'd0);
        for (int i = 0; i <= 40; i++) begin
            cnt_at(16'(i));
            if (oc_ref !== 1'b0) bad++;
        end
        chk("R5 pwm1 compare zero constant low", 16'(bad), 16'h0);
        bad = 0;
        write_cmp(16'd500);
        for (int i = 0; i <= 400; i++) begin
            cnt_at(16'(i));
            if (oc_ref !== 1'b1) bad++;
        end
        chk("R5 pwm1 compare above reload constant high", 16'(bad), 16'h0);
        write_cmp(16'd100);
    endtask

    task automatic t_pin();
        cfg_mode = 3'b101;
        step();
        cfg_oe = 1'b0; cfg_pol = 1'b0; #1;
        chk("R8 disabled pol0", 16'(oc_pin), 16'h0);
        cfg_pol = 1'b1; #1;
        chk("R8 disabled pol1", 16'(oc_pin), 16'h1);
        cfg_oe = 1'b1; cfg_pol = 1'b0; #1;
        chk("R8 enabled pol0", 16'(oc_pin), 16'h1);
        cfg_pol = 1'b1; #1;
        chk("R8 enabled pol1", 16'(oc_pin), 16'h0);
        cfg_mode = 3'b100;
        step();
        chk("R8 enabled pol1 ref low", 16'(oc_pin), 16'h1);
        cfg_oe = 1'b0; cfg_pol = 1'b0;
    endtask

    task automatic t_flag();
        cfg_irq_en = 1'b0;
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk("R9 cleared", 16'(cmp_flag), 16'h0);
        cnt_at(16'd42);
        chk("R9 no set off match", 16'(cmp_flag), 16'h0);
        cnt_at(16'd100);
        chk("R9 set on match", 16'(cmp_flag), 16'h1);
        chk("R9 irq masked", 16'(irq), 16'h0);
        cfg_irq_en = 1'b1; #1;
        chk("R9 irq enabled", 16'(irq), 16'h1);
        flag_clr = 1'b1;
        cnt_at(16'd100);
        chk("R9 set wins over clear", 16'(cmp_flag), 16'h1);
        step();
        flag_clr = 1'b0;
        chk("R9 clear", 16'(cmp_flag), 16'h0);
        chk("R9 irq drops", 16'(irq), 16'h0);
    endtask

    initial begin
        rst = 1'b1; cnt_val = '0; cnt_adv = 1'b0; upd_evt = 1'b0;
        cfg_mode = 3'b000; cfg_preload = 1'b0; cfg_pol = 1'b0; cfg_oe = 1'b0;
        cfg_irq_en = 1'b0; cmp_wr = 1'b0; cmp_wdata = '0; flag_clr = 1'b0;
        #1;
        t_reset();
        t_direct();
        t_preload();
        t_force();
        t_set_clear();
        t_toggle();
        t_freeze();
        t_pwm();
        t_pin();
        t_flag();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule